// File: doc/BRIEF.md
# Single-Precision Classifier and Comparator

This block inspects two 32-bit single-precision floating-point words. It sorts each word into a category: zero, subnormal, normal, infinity or not-a-number. It also reports how the two values are ordered numerically. The logic is purely combinational, so a result follows its operands within the same cycle.

Ordering is read directly from the encoded fields, with no conversion to another format. The sign bit separates operands of opposite sign. When the signs agree, the biased exponent field is compared first and the significand field second. For two negative operands the outcome is inverted. If either operand is not-a-number, the pair is unordered and none of the three ordering outputs is raised. Subnormal values are treated as ordinary finite values for ordering.

The field widths are parameters. The defaults give the single-precision layout: 8 exponent bits and 23 significand bits under one sign bit.

Top module: `fp_class_compare`

## Requirements
- R1: Each class output is a 5-bit one-hot code with bit 0 zero, bit 1 subnormal, bit 2 normal, bit 3 infinity, bit 4 not-a-number.
- R2: A word whose exponent field and significand field are both zero is classed as zero, whatever its sign bit (bit 31).
- R3: A word with an all-zero exponent field and a non-zero significand is classed as subnormal.
- R4: A word whose exponent field lies in 1 to 254 (bits 30:23) is classed as normal.
- R5: A word with exponent field 255 and a zero significand (bits 22:0) is classed as infinity.
- R6: A word with exponent field 255 and a non-zero significand is classed as not-a-number.
- R7: When either operand is not-a-number, `unordered` is high and `lessThan`, `equalTo` and `greaterThan` are all low.
- R8: When the sign bits differ and the operands are not both zero, the operand with sign bit 1 is the lesser one.
- R9: For two positive operands, the one with the larger exponent field is the greater one, including infinity against any finite value.
- R10: For operands with equal signs and equal exponent fields, the larger significand field gives the larger magnitude.
- R11: For two negative operands, the larger magnitude is the lesser value.
- R12: Positive zero and negative zero compare as equal, in either order.
- R13: For any pair without a not-a-number operand, exactly one of `lessThan`, `equalTo` and `greaterThan` is high, and `equalTo` is high only for bit-identical words or a pair of zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand word |
| opB | input | 32 | Second operand word |
| classA | output | 5 | One-hot category of opA |
| classB | output | 5 | One-hot category of opB |
| lessThan | output | 1 | opA is numerically below opB |
| equalTo | output | 1 | opA equals opB numerically |
| greaterThan | output | 1 | opA is numerically above opB |
| unordered | output | 1 | At least one operand is not-a-number |

## Verification
Every output is a combinational function of the two present operands, so every result is due in the same cycle as its stimulus, with no register delay. The bench applies each operand pair on a falling clock edge. It compares both class codes and the ordering outputs against its behavioural model at the following rising edge, so the logic has half a period to settle. The model works independently of the design: it maps each word to a signed integer key, with sign and magnitude folded in and both zeros mapped to the same key. Directed pairs cover each category boundary and each sign combination, and a long pseudo-random run covers the remaining cases.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int CLASS_W   = 5;
  localparam int CLS_ZERO  = 0;
  localparam int CLS_SUB   = 1;
  localparam int CLS_NORM  = 2;
  localparam int CLS_INF   = 3;
  localparam int CLS_NAN   = 4;

  // Strobes from the ordering control into the magnitude datapath.
  typedef struct packed {
    logic unord;     // a not-a-number operand is present
    logic bothZero;  // both operands are zeros of any sign
    logic signSplit; // operand signs differ
    logic aNeg;      // sign of operand A
    logic flip;      // both negative: invert magnitude sense
  } ordStrobeT;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]            word,
  output logic [fpcmp_pkg::CLASS_W-1:0]   cls
);
  import fpcmp_pkg::*;

  localparam int EXP_LO = MAN_W;
  localparam int EXP_HI = MAN_W + EXP_W - 1;

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             expAllOne;
  logic             expAllZero;
  logic             manZero;

  always_comb begin
    expField   = word[EXP_HI:EXP_LO];
    manField   = word[MAN_W-1:0];
    expAllOne  = &expField;
    expAllZero = ~|expField;
    manZero    = ~|manField;
    cls             = '0;
    cls[CLS_ZERO]   = expAllZero & manZero;
    cls[CLS_SUB]    = expAllZero & ~manZero;
    cls[CLS_NORM]   = ~expAllZero & ~expAllOne;
    cls[CLS_INF]    = expAllOne & manZero;
    cls[CLS_NAN]    = expAllOne & ~manZero;
  end

  always_comb begin
    p_class_onehot_r1: assert ($onehot(cls))
      else $error("class code not one-hot");
    p_special_exp_r6: assert (!(cls[CLS_NAN] || cls[CLS_INF]) || (word[EXP_HI:EXP_LO] == '1))
      else $error("special class without reserved exponent");
  end

endmodule

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl (
  input  logic [fpcmp_pkg::CLASS_W-1:0] clsA,
  input  logic [fpcmp_pkg::CLASS_W-1:0] clsB,
  input  logic                          signA,
  input  logic                          signB,
  output fpcmp_pkg::ordStrobeT          strobe
);
  import fpcmp_pkg::*;

  always_comb begin
    strobe.unord     = clsA[CLS_NAN] | clsB[CLS_NAN];
    strobe.bothZero  = clsA[CLS_ZERO] & clsB[CLS_ZERO];
    strobe.signSplit = signA ^ signB;
    strobe.aNeg      = signA;
    strobe.flip      = signA & signB;
  end

  always_comb begin
    p_strobe_excl_r11: assert (!(strobe.flip && strobe.signSplit))
      else $error("flip and sign split together");
    p_zero_not_nan_r12: assert (!(strobe.bothZero && strobe.unord))
      else $error("zero pair flagged unordered");
  end

endmodule

// File: rtl/fpcmp_magdp.sv
module fpcmp_magdp #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]   opA,
  input  logic [EXP_W+MAN_W:0]   opB,
  input  fpcmp_pkg::ordStrobeT   strobe,
  output logic                   lessThan,
  output logic                   equalTo,
  output logic                   greaterThan
);
  localparam int EXP_LO = MAN_W;
  localparam int EXP_HI = MAN_W + EXP_W - 1;

  logic [EXP_W-1:0] expA, expB;
  logic [MAN_W-1:0] manA, manB;
  logic expGt, expEq, manGt, manEq;
  logic magGt, magEq, magLt;

  always_comb begin
    expA  = opA[EXP_HI:EXP_LO];
    expB  = opB[EXP_HI:EXP_LO];
    manA  = opA[MAN_W-1:0];
    manB  = opB[MAN_W-1:0];
    expGt = expA > expB;
    expEq = expA == expB;
    manGt = manA > manB;
    manEq = manA == manB;
    magGt = expGt | (expEq & manGt);
    magEq = expEq & manEq;
    magLt = ~magGt & ~magEq;
  end

  always_comb begin
    lessThan    = 1'b0;
    equalTo     = 1'b0;
    greaterThan = 1'b0;
    if (strobe.unord) begin
      lessThan = 1'b0;
    end else if (strobe.bothZero) begin
      equalTo = 1'b1;
    end else if (strobe.signSplit) begin
      lessThan    = strobe.aNeg;
      greaterThan = ~strobe.aNeg;
    end else if (strobe.flip) begin
      lessThan    = magGt;
      equalTo     = magEq;
      greaterThan = magLt;
    end else begin
      lessThan    = magLt;
      equalTo     = magEq;
      greaterThan = magGt;
    end
  end

  always_comb begin
    p_unord_quiet_r7: assert (!strobe.unord || !(lessThan || equalTo || greaterThan))
      else $error("ordering output raised on unordered pair");
    p_one_result_r13: assert (strobe.unord || $onehot({lessThan, equalTo, greaterThan}))
      else $error("ordered pair without exactly one result");
    p_eq_identity_r13: assert (!equalTo || strobe.bothZero || (opA == opB))
      else $error("equal reported for distinct non-zero words");
    p_split_sign_r8: assert (!(strobe.signSplit && !strobe.unord && !strobe.bothZero)
                             || (lessThan == opA[EXP_W+MAN_W]))
      else $error("sign split ordering wrong");
  end

endmodule

// File: rtl/fp_class_compare.sv
module fp_class_compare #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]            opA,
  input  logic [EXP_W+MAN_W:0]            opB,
  output logic [fpcmp_pkg::CLASS_W-1:0]   classA,
  output logic [fpcmp_pkg::CLASS_W-1:0]   classB,
  output logic                            lessThan,
  output logic                            equalTo,
  output logic                            greaterThan,
  output logic                            unordered
);
  import fpcmp_pkg::*;

  localparam int WORD_W  = EXP_W + MAN_W + 1;
  localparam int SIGN_IX = WORD_W - 1;
  localparam int N_OPS   = 2;

  logic [WORD_W-1:0]  opArr  [N_OPS];
  logic [CLASS_W-1:0] clsArr [N_OPS];
  ordStrobeT          strobe;

  assign opArr[0] = opA;
  assign opArr[1] = opB;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word (opArr[i]),
      .cls  (clsArr[i])
    );
  end

  fpcmp_ctrl u_ctrl (
    .clsA   (clsArr[0]),
    .clsB   (clsArr[1]),
    .signA  (opA[SIGN_IX]),
    .signB  (opB[SIGN_IX]),
    .strobe (strobe)
  );

  fpcmp_magdp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .opA         (opA),
    .opB         (opB),
    .strobe      (strobe),
    .lessThan    (lessThan),
    .equalTo     (equalTo),
    .greaterThan (greaterThan)
  );

  assign classA    = clsArr[0];
  assign classB    = clsArr[1];
  assign unordered = strobe.unord;

endmodule

// File: tb/fp_class_compare_tb.sv
module fp_class_compare_tb;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  classA, classB;
  logic        lessThan, equalTo, greaterThan, unordered;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  fp_class_compare u_dut (
    .opA(opA), .opB(opB), .classA(classA), .classB(classB),
    .lessThan(lessThan), .equalTo(equalTo),
    .greaterThan(greaterThan), .unordered(unordered)
  );

  function automatic logic [4:0] refClass(logic [31:0] w);
    int e = int'(w[30:23]);
    int m = int'(w[22:0]);
    if (e == 0)   return (m == 0) ? 5'b00001 : 5'b00010;
    if (e == 255) return (m == 0) ? 5'b01000 : 5'b10000;
    return 5'b00100;
  endfunction

  function automatic longint keyOf(logic [31:0] w);
    longint mag = longint'(w[30:0]);
    return w[31] ? -mag : mag;
  endfunction

  // expected {unordered, greaterThan, equalTo, lessThan}
  function automatic logic [3:0] refOrder(logic [31:0] a, logic [31:0] b);
    longint ka, kb;
    if (refClass(a) == 5'b10000 || refClass(b) == 5'b10000) return 4'b1000;
    ka = keyOf(a);
    kb = keyOf(b);
    if (ka < kb) return 4'b0001;
    if (ka > kb) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic check(string tag, string what, logic [4:0] act, logic [4:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, string tag);
    @(negedge clk);
    opA = a;
    opB = b;
    @(posedge clk);
    check(tag, "classA", classA, refClass(a));
    check(tag, "classB", classB, refClass(b));
    check(tag, "order", {1'b0, unordered, greaterThan, equalTo, lessThan},
          {1'b0, refOrder(a, b)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsrA;
    logic [31:0] lfsrB;
    @(posedge clk);
    check("R1", "reset classA", classA, 5'b00001);
    check("R12", "reset order", {1'b0, unordered, greaterThan, equalTo, lessThan}, 5'b00010);
    apply(32'h0000_0000, 32'h8000_0000, "R2");
    apply(32'h8000_0000, 32'h0000_0000, "R12");
    apply(32'h0000_0001, 32'h807F_FFFF, "R3");
    apply(32'h0080_0000, 32'h7F7F_FFFF, "R4");
    apply(32'h7F80_0000, 32'hFF80_0000, "R5");
    apply(32'h7F80_0001, 32'h3F80_0000, "R6");
    apply(32'h3F80_0000, 32'hFFC0_0000, "R7");
    apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R7");
    apply(32'hC0A0_0000, 32'h40A0_0000, "R8");
    apply(32'h0000_0000, 32'hC1E6_0000, "R8");
    apply(32'h4100_0000, 32'h40FF_FFFF, "R9");
    apply(32'h7F7F_FFFF, 32'h7F80_0000, "R9");
    apply(32'h3FC0_0000, 32'h3FA0_0000, "R10");
    apply(32'h0000_0002, 32'h0000_0003, "R10");
    apply(32'hC1E6_0000, 32'hC0A0_0000, "R11");
    apply(32'hFF80_0000, 32'hFF7F_FFFF, "R11");
    apply(32'h8000_0001, 32'h8000_0000, "R11");
    apply(32'h4248_0000, 32'h4248_0000, "R13");
    apply(32'hC248_0000, 32'hC248_0000, "R13");
    lfsrA = 32'h1234_5678;
    lfsrB = 32'h9ABC_DEF1;
    for (int i = 0; i < 400; i++) begin
      lfsrA = {lfsrA[30:0], lfsrA[31] ^ lfsrA[21] ^ lfsrA[1] ^ lfsrA[0]};
      lfsrB = {lfsrB[30:0], lfsrB[31] ^ lfsrB[21] ^ lfsrB[1] ^ lfsrB[0]};
      if (i % 4 == 0) apply(lfsrA, {lfsrA[31:8], lfsrB[7:0]}, "R13");
      else            apply(lfsrA, lfsrB, "R13");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule